// File: doc/BRIEF.md
# UART Oversampling Tick Source

This block makes the 16x oversampling tick that paces a serial transmitter and receiver. It gives a single-cycle enable, `tick_16x`, on one of three timing schemes. The fixed scheme derives the tick straight from the core clock, so the bit rate is the clock divided by 16 or by 32. The timer scheme passes on overflow pulses from an external timer, at full rate or halved. The generator scheme uses a private down-counter that reloads from a 16-bit divisor.

The divisor is written one byte at a time through a shared byte bus, with a separate strobe for each byte. The generator and the overflow halver keep running whichever scheme is selected. This lets the timer serve other purposes while the generator paces the serial link, and lets the link switch schemes without restarting either source. Every tick comes out one clock after the cycle that caused it.

Top module: `baud_tick_src`

## Requirements
- R1: While `rst_n` is low, `tick_16x` is 0.
- R2: With `fixed_mode`=1 and `rate_dbl`=1, `tick_16x` is 1 on every cycle, which gives a bit rate of clock/16.
- R3: With `fixed_mode`=1 and `rate_dbl`=0, `tick_16x` is 1 on exactly every other cycle, never on two cycles in a row, which gives a bit rate of clock/32.
- R4: `fixed_mode`=1 selects the fixed scheme whatever the value of `use_gen`.
- R5: With `fixed_mode`=0, `use_gen`=0 and `rate_dbl`=1, `tick_16x` is 1 in the cycle after each cycle where `tmr_ovf` is 1, and 0 otherwise.
- R6: With `fixed_mode`=0, `use_gen`=0 and `rate_dbl`=0, `tick_16x` is 1 in the cycle after the 2nd, 4th, 6th, … overflow pulse, counted since reset. Pulses seen while another scheme is selected also count.
- R7: With `fixed_mode`=0 and `use_gen`=1, ticks are spaced exactly D cycles apart. D is {high byte, low byte}: the byte written with `div_wr_hi` forms bits 15:8, and the byte written with `div_wr_lo` forms bits 7:0.
- R8: A divisor of 0 behaves as 1, so a tick comes on every cycle.
- R9: A divisor write made partway through a count leaves that count alone. The new value is used from the next reload onward.
- R10: The generator keeps counting while another scheme is selected. After it is selected again, its ticks keep their original phase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| fixed_mode | input | 1 | 1: fixed clock/16 or clock/32 scheme |
| rate_dbl | input | 1 | Rate doubling control |
| use_gen | input | 1 | In variable mode, 1 selects the generator and 0 the timer |
| tmr_ovf | input | 1 | Single-cycle overflow pulse from external timer |
| div_wr_hi | input | 1 | Write strobe for divisor high byte |
| div_wr_lo | input | 1 | Write strobe for divisor low byte |
| div_wdata | input | 8 | Divisor byte data |
| tick_16x | output | 1 | Single-cycle 16x oversampling tick |

## Verification
The generator is swept over every divisor from 0 to 20 and over several larger values that cross the byte boundary (255, 256, 257, 1000, 4660). Each measured tick gap separates the zero case, the off-by-one reload cases and errors in byte ordering. The timer scheme is driven with a pseudo-random overflow stream in both halving settings and checked cycle by cycle. Because one overflow pulse is made while the fixed scheme is selected, this also shows whether the halver counts pulses outside its own mode. Separate runs write the divisor mid-count and leave the generator deselected for a while, which tells a reload-time update and a free-running counter apart from an immediate update and a counter that is gated.

// File: rtl/baud_pkg.sv
package baud_pkg;
  typedef enum logic [1:0] {
    SRC_FIXED = 2'd0,
    SRC_TIMER = 2'd1,
    SRC_GEN   = 2'd2
  } baud_src_e;
endpackage

// File: rtl/baud_fixed_div.sv
module baud_fixed_div (
  input  logic clk,
  input  logic rst_n,
  input  logic rate_dbl,
  output logic tick_raw
);
  logic ph_q, ph_d;

  always_comb begin
    ph_d = ~ph_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ph_q <= 1'b0;
    else        ph_q <= ph_d;
  end

  assign tick_raw = rate_dbl | ph_q;

  // R3: in halved mode no two raw ticks follow each other
  assert_fix_alternate_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!rate_dbl && tick_raw) |=> (rate_dbl || !tick_raw));
endmodule

// File: rtl/baud_tmr_half.sv
module baud_tmr_half (
  input  logic clk,
  input  logic rst_n,
  input  logic rate_dbl,
  input  logic tmr_ovf,
  output logic tick_raw
);
  logic half_q, half_d, half_en;

  always_comb begin
    half_en = tmr_ovf;
    half_d  = ~half_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       half_q <= 1'b0;
    else if (half_en) half_q <= half_d;
  end

  assign tick_raw = tmr_ovf & (rate_dbl | half_q);

  // R6: the halving phase moves only on an overflow pulse
  assert_half_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !tmr_ovf |=> $stable(half_q));
  // R6: every overflow pulse flips the phase, in any mode
  assert_half_flip_R6: assert property (@(posedge clk) disable iff (!rst_n)
    tmr_ovf |=> (half_q != $past(half_q)));
endmodule

// File: rtl/baud_reload_gen.sv
module baud_reload_gen #(
  parameter int BYTE_W = 8,
  parameter int NBYTES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NBYTES-1:0] byte_we,
  input  logic [BYTE_W-1:0] wdata,
  output logic              tick_raw
);
  localparam int DIV_W = BYTE_W * NBYTES;

  logic [BYTE_W-1:0] div_byte [NBYTES];
  logic [DIV_W-1:0]  div_full;
  logic [DIV_W-1:0]  eff_div;
  logic [DIV_W-1:0]  cnt_q, cnt_d;

  for (genvar b = 0; b < NBYTES; b++) begin : g_byte
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)          div_byte[b] <= '0;
      else if (byte_we[b]) div_byte[b] <= wdata;
    end
  end

  always_comb begin
    div_full = '0;
    for (int b = 0; b < NBYTES; b++) begin
      div_full[b*BYTE_W +: BYTE_W] = div_byte[b];
    end
    eff_div = (div_full == '0) ? DIV_W'(1) : div_full;
  end

  assign tick_raw = (cnt_q <= DIV_W'(1));

  always_comb begin
    if (tick_raw) cnt_d = eff_div;
    else          cnt_d = cnt_q - DIV_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  // R7: for a divisor above one, a tick never repeats on the next cycle
  assert_gen_gap_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (tick_raw && div_full > DIV_W'(1) && !(|byte_we)) |=> !tick_raw);
  // R8: a zero divisor yields a tick on the following cycle too
  assert_gen_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (tick_raw && div_full == '0) |=> tick_raw);
endmodule

// File: rtl/baud_tick_src.sv
module baud_tick_src #(
  parameter int BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              fixed_mode,
  input  logic              rate_dbl,
  input  logic              use_gen,
  input  logic              tmr_ovf,
  input  logic              div_wr_hi,
  input  logic              div_wr_lo,
  input  logic [BYTE_W-1:0] div_wdata,
  output logic              tick_16x
);
  import baud_pkg::*;

  localparam int NBYTES = 2;

  logic rst_meta_n, rst_sync_n;
  logic fix_raw, tmr_raw, gen_raw;
  logic tick_d, tick_q;
  baud_src_e src;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_n <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rst_meta_n <= 1'b1;
      rst_sync_n <= rst_meta_n;
    end
  end

  baud_fixed_div u_fix (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .rate_dbl (rate_dbl),
    .tick_raw (fix_raw)
  );

  baud_tmr_half u_tmr (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .rate_dbl (rate_dbl),
    .tmr_ovf  (tmr_ovf),
    .tick_raw (tmr_raw)
  );

  baud_reload_gen #(.BYTE_W(BYTE_W), .NBYTES(NBYTES)) u_gen (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .byte_we  ({div_wr_hi, div_wr_lo}),
    .wdata    (div_wdata),
    .tick_raw (gen_raw)
  );

  always_comb begin
    if (fixed_mode)   src = SRC_FIXED;
    else if (use_gen) src = SRC_GEN;
    else              src = SRC_TIMER;
  end

  always_comb begin
    unique case (src)
      SRC_FIXED: tick_d = fix_raw;
      SRC_TIMER: tick_d = tmr_raw;
      SRC_GEN:   tick_d = gen_raw;
      default:   tick_d = 1'b0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) tick_q <= 1'b0;
    else             tick_q <= tick_d;
  end

  assign tick_16x = tick_q;

  // R4: fixed scheme wins over the generator select
  assert_fixed_wins_R4: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (fixed_mode && rate_dbl) |=> tick_16x);
  // R5: undivided timer mode forwards each overflow one cycle later
  assert_tmr_fwd_R5: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (!fixed_mode && !use_gen && rate_dbl && tmr_ovf) |=> tick_16x);
  // R7: a generator tick reaches the output when the generator is selected
  assert_gen_fwd_R7: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (!fixed_mode && use_gen && gen_raw) |=> tick_16x);
  // R5: in timer mode no output tick without a preceding overflow
  assert_tmr_quiet_R5: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (!fixed_mode && !use_gen && !tmr_ovf) |=> !tick_16x);
endmodule

// File: tb/sim_baud_tick_src.sv
module sim_baud_tick_src;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 200000;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       fixed_mode = 1'b1;
  logic       rate_dbl = 1'b1;
  logic       use_gen = 1'b1;
  logic       tmr_ovf = 1'b0;
  logic       div_wr_hi = 1'b0;
  logic       div_wr_lo = 1'b0;
  logic [7:0] div_wdata = 8'd0;
  logic       tick_16x;

  int checks = 0;
  int errors = 0;
  bit half_m = 1'b0;
  logic [15:0] lfsr = 16'hACE1;

  always #(CLK_PERIOD/2) clk = ~clk;

  baud_tick_src u0 (
    .clk(clk), .rst_n(rst_n), .fixed_mode(fixed_mode), .rate_dbl(rate_dbl),
    .use_gen(use_gen), .tmr_ovf(tmr_ovf), .div_wr_hi(div_wr_hi),
    .div_wr_lo(div_wr_lo), .div_wdata(div_wdata), .tick_16x(tick_16x)
  );

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic step(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic set_div(input int d);
    div_wdata = 8'((d >> 8) & 8'hFF);
    div_wr_hi = 1'b1;
    @(negedge clk);
    div_wr_hi = 1'b0;
    div_wdata = 8'(d & 8'hFF);
    div_wr_lo = 1'b1;
    @(negedge clk);
    div_wr_lo = 1'b0;
  endtask

  task automatic wait_tick(output int n);
    n = 0;
    do begin
      @(negedge clk);
      n++;
    end while (!tick_16x && n < 70000);
  endtask

  task automatic next_ovf(output logic o);
    lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    o = lfsr[0] & lfsr[3];
  endtask

  task automatic timer_run(input logic dbl, input string req);
    int mism = 0;
    int ticks = 0;
    int exp_ticks = 0;
    logic exp_prev = 1'b0;
    logic o;
    rate_dbl = dbl;
    fixed_mode = 1'b0;
    use_gen = 1'b0;
    tmr_ovf = 1'b0;
    step(1);
    for (int c = 0; c < 300; c++) begin
      if (tick_16x !== exp_prev) mism++;
      if (tick_16x) ticks++;
      next_ovf(o);
      tmr_ovf = o;
      exp_prev = o & (dbl | half_m);
      if (exp_prev) exp_ticks++;
      if (o) half_m = ~half_m;
      @(negedge clk);
    end
    if (tick_16x !== exp_prev) mism++;
    if (tick_16x) ticks++;
    tmr_ovf = 1'b0;
    check(req, mism, 0);
    check(req, ticks, exp_ticks);
  endtask

  initial begin
    #(CLK_PERIOD * WATCHDOG);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int g;
    int cnt;
    int pairs;
    int el;
    logic prev;
    int dl [26] = '{0,1,2,3,4,5,6,7,8,9,10,11,12,13,14,15,16,17,18,19,20,
                    255,256,257,1000,4660};

    // R1: tick stays low under reset even with fixed every-cycle mode
    step(3);
    check("R1", int'(tick_16x), 0);
    rst_n = 1'b1;
    step(6);

    // R2 and R4: fixed, doubled; use_gen high is ignored
    set_div(7);
    fixed_mode = 1'b1; use_gen = 1'b1; rate_dbl = 1'b1;
    step(2);
    cnt = 0;
    for (int i = 0; i < 32; i++) begin @(negedge clk); if (tick_16x) cnt++; end
    check("R2/R4 every cycle", cnt, 32);

    // R3: fixed, halved
    rate_dbl = 1'b0;
    tmr_ovf = 1'b1;         // one overflow while fixed is selected (R6)
    half_m = ~half_m;
    step(1);
    tmr_ovf = 1'b0;
    step(2);
    cnt = 0; pairs = 0; prev = tick_16x;
    for (int i = 0; i < 32; i++) begin
      @(negedge clk);
      if (tick_16x) cnt++;
      if (tick_16x && prev) pairs++;
      prev = tick_16x;
    end
    check("R3 count", cnt, 16);
    check("R3 adjacent", pairs, 0);

    // R5 and R6: timer overflow source
    timer_run(1'b1, "R5");
    timer_run(1'b0, "R6");

    // R7 and R8: generator divisor sweep
    fixed_mode = 1'b0; use_gen = 1'b1;
    foreach (dl[k]) begin
      set_div(dl[k]);
      wait_tick(g);
      wait_tick(g);
      for (int r = 0; r < 3; r++) begin
        wait_tick(g);
        check(dl[k] == 0 ? "R8 zero divisor" : "R7 divisor gap", g,
              dl[k] == 0 ? 1 : dl[k]);
      end
    end

    // R9: write in the middle of a count
    set_div(40);
    wait_tick(g);
    wait_tick(g);
    step(10);
    set_div(5);
    wait_tick(g);
    check("R9 current count kept", g + 12, 40);
    wait_tick(g);
    check("R9 new divisor used", g, 5);

    // R10: generator keeps phase while deselected
    set_div(9);
    wait_tick(g);
    wait_tick(g);
    use_gen = 1'b0;
    step(23);
    el = 23;
    use_gen = 1'b1;
    wait_tick(g);
    el += g;
    check("R10 phase kept", el % 9, 0);
    wait_tick(g);
    check("R10 period", g, 9);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule